// File: doc/BRIEF.md
# Microcode Program Counter Sequencer

This block keeps the 10-bit program counter of a small event-driven microcore and computes the next fetch address every clock. The instruction decoder hands it a control-flow request (sequential step, relative jump, far jump, call, return or interrupt return), a branch-condition bit and a 5-bit signed offset field. Two far-jump registers, a single subroutine return register and a single interrupt return register live inside the block. None of these return registers is a stack.

A software interrupt request takes precedence over whatever the decoder presents. The block records the interrupted address, jumps to a configurable routine address and marks an interrupt as active. Further requests are ignored until the routine ends with an interrupt return. That return either resumes at the recorded address or restarts at a configurable entry address. A hold input freezes sequencing while the core waits on an event or a multicycle operation. The current fetch address drives the code RAM directly.

Top module: `mseq_pc_top`

## Requirements
- R1: After a clock with `rst_n` low, `fetch_addr` is 0 and `irq_active` is 0. The two far registers, the call return register and the interrupt return register are all 0.
- R2: With `flow_op` = 0 (step), `flow_op` = 7 (treated as step), or a conditional jump (`flow_op` 1 or 2) with `cond_ok` = 0, the next `fetch_addr` is the current value plus 1, modulo 1024.
- R3: With `flow_op` = 1 and `cond_ok` = 1, the next `fetch_addr` is the current value plus `rel_ofs`, read as two's complement in the range -16 to +15, modulo 1024.
- R4: With `flow_op` = 2 and `cond_ok` = 1, the next `fetch_addr` is far register 0 when `far_sel` = 0, and far register 1 when `far_sel` = 1.
- R5: When bit i of `jr_load` is high at a clock edge, far register i takes `jr_value`. This happens whatever `hold` and `swi_req` are. A far jump in that same cycle uses the old register content.
- R6: `flow_op` = 3 (call relative) and `flow_op` = 4 (call far) ignore `cond_ok`. Each stores the current `fetch_addr` in the call return register and jumps to the R3 or R4 target.
- R7: `flow_op` = 5 (return) loads `fetch_addr` with the call return register plus 1, modulo 1024.
- R8: `swi_req` while `irq_active` is 0 is accepted, whatever `hold` and `flow_op` are. The current `fetch_addr` goes to the interrupt return register, `fetch_addr` becomes `irq_vector` and `irq_active` goes to 1. The decoded request of that cycle is dropped, and the call return register is left unchanged.
- R9: `swi_req` while `irq_active` is 1 has no effect, and the decoded request executes normally.
- R10: `flow_op` = 6 (interrupt return) clears `irq_active`. It loads `fetch_addr` with `restart_addr` when `iret_restart` = 1, and otherwise with the interrupt return register.
- R11: With `hold` = 1 and no accepted interrupt, `fetch_addr`, the call return register and `irq_active` keep their values, and the decoded request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hold | input | 1 | Freeze sequencing (wait or multicycle operation) |
| flow_op | input | 3 | Decoded control-flow request |
| cond_ok | input | 1 | Branch condition for conditional jumps |
| rel_ofs | input | 5 | Signed relative offset |
| far_sel | input | 1 | Far register select |
| jr_load | input | 2 | Per-register far load strobes |
| jr_value | input | 10 | Value for far register load |
| swi_req | input | 1 | Software interrupt request |
| irq_vector | input | 10 | Interrupt routine address |
| iret_restart | input | 1 | Interrupt return to restart address instead of saved one |
| restart_addr | input | 10 | Restart entry address |
| fetch_addr | output | 10 | Code RAM fetch address (program counter) |
| irq_active | output | 1 | Interrupt routine in progress |

## Verification
Several properties are checked on every cycle. The step increment, the freeze under hold, interrupt entry to the vector with the flag set, and the flag staying set until an interrupt return are all checked this way. So are the clearing by that return and the loading of far registers. Other behaviour only shows up in the bench's scenarios. That includes the modulo-1024 wrap of negative and positive offsets and the old-value read when a far register loads in the same cycle as a far jump. It also includes a return landing one past the call site, the call register surviving a hold and an interrupt, and the choice between resume and restart on interrupt return.

// File: rtl/mseq_pkg.sv
// Package: shared control-flow encoding for the program counter sequencer.
// Assumes the decoder drives these codes on flow_op unchanged.
package mseq_pkg;
    typedef enum logic [2:0] {
        FLOW_STEP  = 3'd0,
        FLOW_JREL  = 3'd1,
        FLOW_JFAR  = 3'd2,
        FLOW_CALLR = 3'd3,
        FLOW_CALLF = 3'd4,
        FLOW_RET   = 3'd5,
        FLOW_IRET  = 3'd6,
        FLOW_RSVD  = 3'd7
    } flow_op_e;
endpackage

// File: rtl/mseq_target_calc.sv
// Module: combinational target arithmetic.
// Produces the sequential and relative addresses from the current address.
// Assumes the offset is two's complement and all arithmetic wraps at 2**AW.
module mseq_target_calc #(
    parameter int AW = 10,
    parameter int OW = 5
) (
    input  logic [AW-1:0] cur_addr,
    input  logic [OW-1:0] ofs,
    output logic [AW-1:0] seq_addr,
    output logic [AW-1:0] rel_addr
);
    logic [AW-1:0] ofs_ext;

    // Sign-extend the offset and form both candidate addresses.
    always_comb begin
        ofs_ext  = {{(AW-OW){ofs[OW-1]}}, ofs};
        seq_addr = cur_addr + AW'(1);
        rel_addr = cur_addr + ofs_ext;
    end
endmodule

// File: rtl/mseq_jump_regs.sv
// Module: bank of far-jump address registers with per-register load strobes.
// Assumes loads are independent of the sequencer hold; readers see the
// value held before the current edge.
module mseq_jump_regs #(
    parameter int AW  = 10,
    parameter int NJR = 2,
    localparam int SW = (NJR > 1) ? $clog2(NJR) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NJR-1:0] ld,
    input  logic [AW-1:0]  ld_val,
    input  logic [SW-1:0]  sel,
    output logic [AW-1:0]  far_addr
);
    logic [AW-1:0] jr_q [NJR];

    for (genvar g = 0; g < NJR; g++) begin : g_jr
        // Hold one far address, replaced when its strobe is high.
        always_ff @(posedge clk) begin
            if (!rst_n)
                jr_q[g] <= '0;
            else if (ld[g])
                jr_q[g] <= ld_val;
        end

        a_r5_jr_load: assert property (@(posedge clk) disable iff (!rst_n)
            ld[g] |=> jr_q[g] == $past(ld_val));
    end

    // Select the register named by the instruction operand.
    always_comb begin
        far_addr = jr_q[0];
        for (int i = 0; i < NJR; i++)
            if (SW'(i) == sel) far_addr = jr_q[i];
    end
endmodule

// File: rtl/mseq_irq_ctrl.sv
// Module: software interrupt entry and exit bookkeeping.
// Accepts a request only when no routine is active, records the address
// that was about to execute, and offers the return target.
// Assumes iret_go is never raised in a cycle where swi_take is high.
module mseq_irq_ctrl #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          swi_req,
    input  logic [AW-1:0] cur_addr,
    input  logic          iret_go,
    input  logic          iret_restart,
    input  logic [AW-1:0] restart_addr,
    output logic          swi_take,
    output logic          active,
    output logic [AW-1:0] iret_addr
);
    logic [AW-1:0] saved_q;

    // A request is taken only outside a running routine.
    assign swi_take = swi_req && !active;

    // Track the in-routine flag and the interrupted address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            saved_q <= '0;
        end else if (swi_take) begin
            active  <= 1'b1;
            saved_q <= cur_addr;
        end else if (iret_go) begin
            active  <= 1'b0;
        end
    end

    // Pick resume or restart for the interrupt return.
    assign iret_addr = iret_restart ? restart_addr : saved_q;

    a_r8_entry_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        swi_take |=> active && saved_q == $past(cur_addr));
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        active && !iret_go |=> active);
    a_r10_iret_clears: assert property (@(posedge clk) disable iff (!rst_n)
        iret_go |=> !active);
endmodule

// File: rtl/mseq_pc_top.sv
// Module: program counter sequencer top.
// Holds the program counter and the call return register, and picks the
// next address from the decoded request, the branch condition, the far
// registers and the interrupt controller.
// Assumes the decoder presents one request per cycle and keeps it stable
// while hold is high.
module mseq_pc_top #(
    parameter int AW  = 10,
    parameter int OW  = 5,
    parameter int NJR = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hold,
    input  logic [2:0]     flow_op,
    input  logic           cond_ok,
    input  logic [OW-1:0]  rel_ofs,
    input  logic           far_sel,
    input  logic [NJR-1:0] jr_load,
    input  logic [AW-1:0]  jr_value,
    input  logic           swi_req,
    input  logic [AW-1:0]  irq_vector,
    input  logic           iret_restart,
    input  logic [AW-1:0]  restart_addr,
    output logic [AW-1:0]  fetch_addr,
    output logic           irq_active
);
    import mseq_pkg::*;

    logic [AW-1:0] pc_q, pc_d, aux_q, aux_d;
    logic [AW-1:0] seq_addr, rel_addr, far_addr, iret_addr;
    logic          swi_take, iret_go;
    flow_op_e      op;

    assign op = flow_op_e'(flow_op);

    mseq_target_calc #(.AW(AW), .OW(OW)) u_calc (
        .cur_addr (pc_q),
        .ofs      (rel_ofs),
        .seq_addr (seq_addr),
        .rel_addr (rel_addr)
    );

    mseq_jump_regs #(.AW(AW), .NJR(NJR)) u_jr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (jr_load),
        .ld_val   (jr_value),
        .sel      (far_sel),
        .far_addr (far_addr)
    );

    mseq_irq_ctrl #(.AW(AW)) u_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .swi_req      (swi_req),
        .cur_addr     (pc_q),
        .iret_go      (iret_go),
        .iret_restart (iret_restart),
        .restart_addr (restart_addr),
        .swi_take     (swi_take),
        .active       (irq_active),
        .iret_addr    (iret_addr)
    );

    // Next-address selection: interrupt entry, then hold, then the request.
    always_comb begin
        pc_d    = pc_q;
        aux_d   = aux_q;
        iret_go = 1'b0;
        if (swi_take) begin
            pc_d = irq_vector;
        end else if (!hold) begin
            unique case (op)
                FLOW_JREL:  pc_d = cond_ok ? rel_addr : seq_addr;
                FLOW_JFAR:  pc_d = cond_ok ? far_addr : seq_addr;
                FLOW_CALLR: begin aux_d = pc_q; pc_d = rel_addr; end
                FLOW_CALLF: begin aux_d = pc_q; pc_d = far_addr; end
                FLOW_RET:   pc_d = aux_q + AW'(1);
                FLOW_IRET:  begin iret_go = 1'b1; pc_d = iret_addr; end
                default:    pc_d = seq_addr;
            endcase
        end
    end

    // Program counter and call return register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            aux_q <= '0;
        end else begin
            pc_q  <= pc_d;
            aux_q <= aux_d;
        end
    end

    assign fetch_addr = pc_q;

    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        !hold && !swi_take && (flow_op == 3'd0 || flow_op == 3'd7)
        |=> fetch_addr == AW'($past(fetch_addr) + 1'b1));
    a_r11_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        hold && !swi_take |=> $stable(fetch_addr) && $stable(aux_q) && $stable(irq_active));
    a_r8_vector: assert property (@(posedge clk) disable iff (!rst_n)
        swi_take |=> fetch_addr == $past(irq_vector) && $stable(aux_q));
    a_r6_call_save: assert property (@(posedge clk) disable iff (!rst_n)
        !hold && !swi_take && (flow_op == 3'd3 || flow_op == 3'd4)
        |=> aux_q == $past(fetch_addr));
endmodule

// File: tb/mseq_pc_top_tb_top.sv
// Bench: directed corners plus seeded random requests against a bench model.
module mseq_pc_top_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hold = 1'b0;
    logic [2:0] flow_op = 3'd0;
    logic       cond_ok = 1'b0;
    logic [4:0] rel_ofs = 5'd0;
    logic       far_sel = 1'b0;
    logic [1:0] jr_load = 2'b00;
    logic [9:0] jr_value = 10'd0;
    logic       swi_req = 1'b0;
    logic [9:0] irq_vector = 10'd0;
    logic       iret_restart = 1'b0;
    logic [9:0] restart_addr = 10'd0;
    logic [9:0] fetch_addr;
    logic       irq_active;

    int n_chk = 0;
    int n_bad = 0;

    logic [9:0] m_pc, m_aux, m_ret;
    logic [9:0] m_jr [2];
    logic       m_act;

    always #10 clk = ~clk;

    mseq_pc_top dut_i (
        .clk(clk), .rst_n(rst_n), .hold(hold), .flow_op(flow_op),
        .cond_ok(cond_ok), .rel_ofs(rel_ofs), .far_sel(far_sel),
        .jr_load(jr_load), .jr_value(jr_value), .swi_req(swi_req),
        .irq_vector(irq_vector), .iret_restart(iret_restart),
        .restart_addr(restart_addr), .fetch_addr(fetch_addr),
        .irq_active(irq_active)
    );

    function automatic logic [9:0] sext_add(logic [9:0] a, logic [4:0] o);
        int s;
        s = (o[4]) ? int'(o) - 32 : int'(o);
        return 10'((int'(a) + s + 1024) % 1024);
    endfunction

    function automatic string tag_of();
        if (swi_req && !m_act) return "R8";
        if (hold) return "R11";
        if (swi_req) return "R9";
        case (flow_op)
            3'd1: return cond_ok ? "R3" : "R2";
            3'd2: return cond_ok ? "R4" : "R2";
            3'd3, 3'd4: return "R6";
            3'd5: return "R7";
            3'd6: return "R10";
            default: return "R2";
        endcase
    endfunction

    // Advance the model by one clock using the inputs now driven.
    task automatic model_step();
        logic [9:0] far, npc, naux, nret;
        logic       nact;
        far = m_jr[far_sel];
        npc = m_pc; naux = m_aux; nret = m_ret; nact = m_act;
        if (swi_req && !m_act) begin
            nret = m_pc; npc = irq_vector; nact = 1'b1;
        end else if (!hold) begin
            case (flow_op)
                3'd1: npc = cond_ok ? sext_add(m_pc, rel_ofs) : m_pc + 10'd1;
                3'd2: npc = cond_ok ? far : m_pc + 10'd1;
                3'd3: begin naux = m_pc; npc = sext_add(m_pc, rel_ofs); end
                3'd4: begin naux = m_pc; npc = far; end
                3'd5: npc = m_aux + 10'd1;
                3'd6: begin npc = iret_restart ? restart_addr : m_ret; nact = 1'b0; end
                default: npc = m_pc + 10'd1;
            endcase
        end
        for (int i = 0; i < 2; i++) if (jr_load[i]) m_jr[i] = jr_value;
        m_pc = npc; m_aux = naux; m_ret = nret; m_act = nact;
    endtask

    task automatic check(string tag);
        n_chk++;
        if (fetch_addr !== m_pc || irq_active !== m_act) begin
            n_bad++;
            $display("FAIL %s: fetch_addr=%0d irq_active=%0b expected %0d/%0b",
                     tag, fetch_addr, irq_active, m_pc, m_act);
        end
    endtask

    // One cycle: inputs already set at a falling edge; check at the next one.
    task automatic step();
        string t;
        t = tag_of();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(t);
    endtask

    task automatic drive(logic [2:0] op, logic c, logic [4:0] o, logic fs);
        flow_op = op; cond_ok = c; rel_ofs = o; far_sel = fs;
        hold = 1'b0; swi_req = 1'b0; jr_load = 2'b00;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7151));
        m_pc = 0; m_aux = 0; m_ret = 0; m_act = 0; m_jr[0] = 0; m_jr[1] = 0;
        repeat (3) @(negedge clk);
        check("R1");
        rst_n = 1'b1;

        // R5: load both far registers during a plain step (R2).
        drive(3'd0, 0, 0, 0); jr_load = 2'b11; jr_value = 10'h3F0; step();
        drive(3'd0, 0, 0, 0); jr_load = 2'b10; jr_value = 10'h005; step();
        // R4: far jump through register 0 and register 1.
        drive(3'd2, 1, 0, 0); step();
        drive(3'd2, 1, 0, 1); step();
        // R5: same-cycle load and far jump uses the old content.
        drive(3'd2, 1, 0, 1); jr_load = 2'b10; jr_value = 10'h200; step();
        drive(3'd2, 1, 0, 1); step();
        // R2: false condition falls through.
        drive(3'd2, 0, 0, 0); step();
        // R3: -16 from a low address wraps, then +15 wraps back.
        drive(3'd0, 0, 0, 0); jr_load = 2'b01; jr_value = 10'd5; step();
        drive(3'd2, 1, 0, 0); step();
        drive(3'd1, 1, 5'b10000, 0); step();
        drive(3'd1, 1, 5'b01111, 0); step();
        drive(3'd1, 0, 5'b01111, 0); step();
        // R6 call relative, R11 hold over a call, R7 return.
        drive(3'd3, 0, 5'd3, 0); step();
        drive(3'd3, 1, 5'd9, 0); hold = 1'b1; step();
        drive(3'd4, 1, 0, 1); hold = 1'b1; step();
        drive(3'd5, 0, 0, 0); step();
        // R8 entry over a held call, R9 ignored request, R10 resume.
        irq_vector = 10'h300;
        drive(3'd3, 1, 5'd2, 0); hold = 1'b1; swi_req = 1'b1; step();
        drive(3'd0, 0, 0, 0); swi_req = 1'b1; step();
        drive(3'd6, 0, 0, 0); iret_restart = 1'b0; step();
        drive(3'd5, 0, 0, 0); step();
        // R10 restart path.
        drive(3'd0, 0, 0, 0); swi_req = 1'b1; step();
        drive(3'd6, 0, 0, 0); iret_restart = 1'b1; restart_addr = 10'h080; step();
        drive(3'd7, 0, 0, 0); step();

        // Seeded random mix across all requests.
        for (int k = 0; k < 3000; k++) begin
            flow_op      = 3'($urandom_range(0, 7));
            cond_ok      = 1'($urandom);
            rel_ofs      = 5'($urandom);
            far_sel      = 1'($urandom);
            hold         = ($urandom_range(0, 5) == 0);
            swi_req      = ($urandom_range(0, 15) == 0);
            jr_load      = {($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0)};
            jr_value     = 10'($urandom);
            irq_vector   = 10'($urandom);
            iret_restart = 1'($urandom);
            restart_addr = 10'($urandom);
            step();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule